// File: doc/BRIEF.md
# Parallel-Bus SAR Conversion Sequencer

This block is the digital control core of a byte-wide successive-approximation converter, seen from the device side of a microprocessor bus. A host writes an 8-bit control byte with chip-select and a write strobe. The byte picks the power state, the conversion clock source, the acquisition style, the input polarity, single-ended or pseudo-differential routing, and a channel address. The block then drives the track/hold control and the analog multiplexer selects. It runs a 10-step binary search against a one-bit comparator input, latches the result, and pulls an active-low interrupt. The host reads the result as two bytes over the same bus.

Every bus strobe and the external conversion clock are synchronized into the system clock domain and edge-detected there. The internal conversion clock is a clock enable divided down from the system clock. The analog track/hold, the reference, the comparator and the DAC live outside this block. The DAC trial code is an output, and the comparator decision comes back as a single input bit.

Top module: `sar_bus_seq`

## Requirements
- R1: The control byte is decoded with bits 7:6 as the power code, bit 5 as the acquisition style (1 = host-timed), bit 4 as input routing (1 = single-ended), bit 3 as polarity (1 = unipolar), and bits 2:0 as the channel address.
- R2: With single-ended routing, `muxPos` equals the address and `negIsCom` is 1. With pseudo-differential routing, `muxPos` equals the address, `muxNeg` equals the address with bit 0 inverted, and `negIsCom` is 0.
- R3: Power codes 2'b10 and 2'b11 select the internal and the external conversion clock. Code 2'b01 (standby) and code 2'b00 (shutdown) keep the previous clock source. They show on `pwrState` as 1 and 2 only while no acquisition or conversion runs; `pwrState` is 0 otherwise and never 3. Reset leaves the external clock selected, `pwrState` 0 and `intN` high.
- R4: With bit 5 = 0, a write starts acquisition (`trackOn` high). Hold begins on the 4th conversion-clock tick after the write, and `intN` falls on the 17th tick (13 conversion ticks).
- R5: With bit 5 = 1, a write starts an acquisition that lasts until another write. A following write with bit 5 = 0 ends acquisition at once, and `intN` falls on the 13th tick after it.
- R6: The search starts with `dacCode` = 0x200 and runs MSB first. A trial bit is kept when `compIn` is high. With `compIn` = (input code >= `dacCode`), the final code equals the input code.
- R7: Unipolar results are straight binary. Bipolar results have bit 9 of the search code inverted, which gives two's complement.
- R8: `busOe` is high while `csN` and `rdN` are both low. With `hiByteSel` = 0, `busOut` is result bits 7:0. With `hiByteSel` = 1, `busOut`[1:0] is result bits 9:8 and bits 7:2 are 0 (unipolar) or copies of result bit 9 (bipolar).
- R9: `intN` goes low when a result is latched. It returns high on the first read falling edge or on any accepted write.
- R10: A write during a conversion abandons it and starts a new sequence from that byte, which needs the full tick count again.
- R11: While `csN` is high, write strobes, read strobes and external clock edges are ignored, and `busOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe; control byte taken on its rising edge |
| rdN | input | 1 | Active-low read strobe |
| hiByteSel | input | 1 | Selects the high result byte on reads |
| extClk | input | 1 | External conversion clock; falling edges are ticks |
| busIn | input | 8 | Control byte from the bus |
| busOut | output | 8 | Result byte toward the bus |
| busOe | output | 1 | Bus output enable (high = drive) |
| compIn | input | 1 | Comparator decision for the current trial code |
| dacCode | output | 10 | Trial code presented to the DAC |
| trackOn | output | 1 | Track/hold in tracking mode |
| muxPos | output | 3 | Positive input channel select |
| muxNeg | output | 3 | Negative input channel select (pseudo-differential) |
| negIsCom | output | 1 | Negative input tied to the common return |
| pwrState | output | 2 | 0 active, 1 standby, 2 shutdown |
| intN | output | 1 | Active-low result-ready interrupt |

## Verification
The bench counts external clock edges one at a time, so it can tell whether hold starts on the 4th tick and whether the result is ready on the 17th. An off-by-one in either counter moves the interrupt one tick early or late. It aborts a conversion part way through, checks that the later address wins, and checks that the full count is needed again. A design that kept the old count would interrupt too soon. It shows that toggling strobes and the clock with chip-select high has no effect: the channel and the remaining tick count stay as they were. It also sweeps every address, routing and polarity in internal clock mode, and tries input codes at 0, 1023 and both sides of mid-scale. This catches a wrong mux pairing, a missing MSB inversion in bipolar mode, and a wrong sign fill in the high byte.

// File: rtl/sar_bus_seq_pkg.sv
package sar_bus_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACQ_INT = 2'd1,
    ST_ACQ_EXT = 2'd2,
    ST_CONV    = 2'd3
  } seqState_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE   = 2'd0,
    PWR_STANDBY  = 2'd1,
    PWR_SHUTDOWN = 2'd2
  } pwr_e;

  // Field order follows the byte on the bus, MSB first.
  typedef struct packed {
    logic [1:0] pwrCode;
    logic       acqExt;
    logic       singleEnd;
    logic       unipolar;
    logic [2:0] addr;
  } ctrlByte_t;

  typedef struct packed {
    logic startConv;
    logic stepEn;
    logic finish;
    logic bipolar;
  } dpStrobe_t;

endpackage

// File: rtl/sar_bus_seq_sync.sv
module sar_bus_seq_sync #(
  parameter int              WIDTH  = 4,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= INIT;
    else        stage[0] <= asyncIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= INIT;
      else        stage[g] <= stage[g-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sar_bus_seq_ctrl.sv
module sar_bus_seq_ctrl
  import sar_bus_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int INT_CLK_DIV = 4,
  parameter int ACQ_EDGES   = 4,
  parameter int CONV_TICKS  = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csLvl,
  input  logic       wrLvl,
  input  logic       rdLvl,
  input  logic       extLvl,
  input  logic [7:0] busIn,
  output dpStrobe_t  stb,
  output logic       intN,
  output logic       trackOn,
  output logic [2:0] muxPos,
  output logic [2:0] muxNeg,
  output logic       negIsCom,
  output logic [1:0] pwrState
);

  localparam int PH_MAX = (ACQ_EDGES > CONV_TICKS) ? ACQ_EDGES : CONV_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int DIV_W  = $clog2(INT_CLK_DIV);
  localparam logic [PH_W-1:0]  ACQ_LAST  = PH_W'(ACQ_EDGES - 1);
  localparam logic [PH_W-1:0]  CONV_LAST = PH_W'(CONV_TICKS - 1);
  localparam logic [PH_W-1:0]  SAR_STEPS = PH_W'(RES_W);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(INT_CLK_DIV - 1);

  // Byte pipeline aligned with the write-strobe synchronizer.
  logic [7:0] dataPipe [SYNC_STAGES];
  logic [7:0] heldByte;
  ctrlByte_t  newCfg;

  logic wrPrev, rdPrev, extPrev;
  logic wrEv, rdEv, extTick, intTick, tick;
  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  seqState_e        state;
  logic             clkExtMode;

  logic [1:0] pwrCodeR;
  logic       singleR, uniR;
  logic [2:0] addrR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) dataPipe[i] <= '0;
      heldByte <= '0;
    end else begin
      dataPipe[0] <= busIn;
      for (int i = 1; i < SYNC_STAGES; i++) dataPipe[i] <= dataPipe[i-1];
      if (!wrLvl) heldByte <= dataPipe[SYNC_STAGES-1];
    end
  end

  assign newCfg  = ctrlByte_t'(heldByte);
  assign wrEv    = wrLvl & ~wrPrev & ~csLvl;
  assign rdEv    = ~rdLvl & rdPrev & ~csLvl;
  assign extTick = ~extLvl & extPrev & ~csLvl;
  assign intTick = (divCnt == DIV_LAST);
  assign tick    = clkExtMode ? extTick : intTick;

  always_comb begin
    stb.startConv = (wrEv & ~newCfg.acqExt & (state == ST_ACQ_EXT)) |
                    (~wrEv & (state == ST_ACQ_INT) & tick & (phase == ACQ_LAST));
    stb.stepEn    = ~wrEv & (state == ST_CONV) & tick & (phase < SAR_STEPS);
    stb.finish    = ~wrEv & (state == ST_CONV) & tick & (phase == CONV_LAST);
    stb.bipolar   = ~uniR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPrev  <= 1'b1;
      rdPrev  <= 1'b1;
      extPrev <= 1'b0;
      divCnt  <= '0;
    end else begin
      wrPrev  <= wrLvl;
      rdPrev  <= rdLvl;
      extPrev <= extLvl;
      divCnt  <= intTick ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= '0;
      intN       <= 1'b1;
      clkExtMode <= 1'b1;
      pwrCodeR   <= 2'b11;
      singleR    <= 1'b1;
      uniR       <= 1'b1;
      addrR      <= '0;
    end else if (wrEv) begin
      pwrCodeR <= newCfg.pwrCode;
      singleR  <= newCfg.singleEnd;
      uniR     <= newCfg.unipolar;
      addrR    <= newCfg.addr;
      intN     <= 1'b1;
      phase    <= '0;
      if (newCfg.pwrCode[1]) clkExtMode <= newCfg.pwrCode[0];
      if (newCfg.acqExt)              state <= ST_ACQ_EXT;
      else if (state == ST_ACQ_EXT)   state <= ST_CONV;
      else                            state <= ST_ACQ_INT;
    end else begin
      if (rdEv) intN <= 1'b1;
      if (stb.startConv) begin
        state <= ST_CONV;
        phase <= '0;
      end else if (stb.finish) begin
        state <= ST_IDLE;
        phase <= '0;
        intN  <= 1'b0;
      end else if (tick && (state == ST_ACQ_INT || state == ST_CONV)) begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign trackOn  = (state == ST_ACQ_INT) || (state == ST_ACQ_EXT);
  assign muxPos   = addrR;
  assign muxNeg   = {addrR[2:1], ~addrR[0]};
  assign negIsCom = singleR;
  assign pwrState = ((state == ST_IDLE) && !pwrCodeR[1])
                    ? (pwrCodeR[0] ? PWR_STANDBY : PWR_SHUTDOWN)
                    : PWR_ACTIVE;

endmodule

// File: rtl/sar_bus_seq_dp.sv
module sar_bus_seq_dp
  import sar_bus_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        stb,
  input  logic             compIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             hiByteSel,
  output logic [RES_W-1:0] dacCode,
  output logic [7:0]       busOut,
  output logic             busOe
);

  localparam int HI_W   = RES_W - 8;
  localparam int FILL_W = 8 - HI_W;
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] kept, trial, resLatch;
  logic             resBip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept     <= '0;
      trial    <= '0;
      resLatch <= '0;
      resBip   <= 1'b0;
    end else begin
      if (stb.startConv) begin
        kept  <= '0;
        trial <= MSB_ONE;
      end else if (stb.stepEn) begin
        if (compIn) kept <= kept | trial;
        trial <= trial >> 1;
      end
      if (stb.finish) begin
        resLatch <= stb.bipolar ? (kept ^ MSB_ONE) : kept;
        resBip   <= stb.bipolar;
      end
    end
  end

  assign dacCode = kept | trial;
  assign busOe   = ~csN & ~rdN;
  assign busOut  = hiByteSel
                   ? {{FILL_W{resBip & resLatch[RES_W-1]}}, resLatch[RES_W-1:8]}
                   : resLatch[7:0];

endmodule

// File: rtl/sar_bus_seq.sv
module sar_bus_seq
  import sar_bus_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int INT_CLK_DIV = 4,
  parameter int ACQ_EDGES   = 4,
  parameter int CONV_TICKS  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             hiByteSel,
  input  logic             extClk,
  input  logic [7:0]       busIn,
  output logic [7:0]       busOut,
  output logic             busOe,
  input  logic             compIn,
  output logic [RES_W-1:0] dacCode,
  output logic             trackOn,
  output logic [2:0]       muxPos,
  output logic [2:0]       muxNeg,
  output logic             negIsCom,
  output logic [1:0]       pwrState,
  output logic             intN
);

  logic [3:0] lvl;
  dpStrobe_t  stb;

  sar_bus_seq_sync #(
    .WIDTH (4),
    .STAGES(SYNC_STAGES),
    .INIT  (4'b1110)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn({csN, wrN, rdN, extClk}),
    .syncOut(lvl)
  );

  sar_bus_seq_ctrl #(
    .RES_W      (RES_W),
    .SYNC_STAGES(SYNC_STAGES),
    .INT_CLK_DIV(INT_CLK_DIV),
    .ACQ_EDGES  (ACQ_EDGES),
    .CONV_TICKS (CONV_TICKS)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .csLvl   (lvl[3]),
    .wrLvl   (lvl[2]),
    .rdLvl   (lvl[1]),
    .extLvl  (lvl[0]),
    .busIn   (busIn),
    .stb     (stb),
    .intN    (intN),
    .trackOn (trackOn),
    .muxPos  (muxPos),
    .muxNeg  (muxNeg),
    .negIsCom(negIsCom),
    .pwrState(pwrState)
  );

  sar_bus_seq_dp #(
    .RES_W(RES_W)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .compIn   (compIn),
    .csN      (csN),
    .rdN      (rdN),
    .hiByteSel(hiByteSel),
    .dacCode  (dacCode),
    .busOut   (busOut),
    .busOe    (busOe)
  );

endmodule

// File: rtl/sar_bus_seq_chk.sv
module sar_bus_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csN,
  input logic             busOe,
  input logic [RES_W-1:0] dacCode,
  input logic             trackOn,
  input logic [1:0]       pwrState,
  input logic             intN
);

  localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  // R6: the first trial after hold is the MSB alone
  assert_first_trial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trackOn) |-> (dacCode == FIRST_TRIAL));

  // R9: the interrupt cannot be pending while the input is tracked
  assert_int_quiet_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trackOn |-> intN);

  // R4: a result only appears after a conversion phase, never straight from tracking
  assert_int_after_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intN) |-> !$past(trackOn));

  // R3: low-power states only while nothing is being acquired
  assert_sleep_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrState != 2'd0) |-> !trackOn);

  // R3: the power state code 3 is unused
  assert_pwr_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwrState != 2'd3);

  // R11: no bus drive without chip select
  assert_bus_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !busOe);

endmodule

bind sar_bus_seq sar_bus_seq_chk #(.RES_W(RES_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .csN     (csN),
  .busOe   (busOe),
  .dacCode (dacCode),
  .trackOn (trackOn),
  .pwrState(pwrState),
  .intN    (intN)
);

// File: tb/sar_bus_seq_tb_top.sv
`timescale 1ns/1ps
module sar_bus_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csN = 1'b1, wrN = 1'b1, rdN = 1'b1, hiByteSel = 1'b0, extClk = 1'b0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic       busOe, compIn, trackOn, negIsCom, intN;
  logic [9:0] dacCode;
  logic [2:0] muxPos, muxNeg;
  logic [1:0] pwrState;
  int         anaBase = 0;
  int         nChecks = 0, nFail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  sar_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .wrN(wrN), .rdN(rdN),
    .hiByteSel(hiByteSel), .extClk(extClk), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .compIn(compIn), .dacCode(dacCode), .trackOn(trackOn),
    .muxPos(muxPos), .muxNeg(muxNeg), .negIsCom(negIsCom),
    .pwrState(pwrState), .intN(intN)
  );

  // Analog front-end model: input code depends on the routed channels.
  function automatic logic [9:0] anaOf(input int base, input int pos, input int neg, input bit com);
    int v;
    v = base + pos * 97 + (com ? 0 : neg * 13);
    return 10'(v & 1023);
  endfunction

  assign compIn = (anaOf(anaBase, int'(muxPos), int'(muxNeg), negIsCom) >= dacCode);

  // Expected 10-bit result from the control byte fields alone.
  function automatic int expRes(input logic [7:0] b, input int base);
    int pos, neg, u;
    pos = int'(b[2:0]);
    neg = pos ^ 1;
    u   = int'(anaOf(base, pos, neg, b[4]));
    return b[3] ? u : (u ^ 32'h200);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    busIn = b;
    wrN = 1'b0;
    cyc(4);
    wrN = 1'b1;
    cyc(6);
  endtask

  task automatic extPulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClk = 1'b1;
      cyc(8);
      extClk = 1'b0;
      cyc(8);
    end
  endtask

  task automatic readByte(input logic hi, output logic [7:0] val, output logic oe);
    @(negedge clk);
    hiByteSel = hi;
    rdN = 1'b0;
    cyc(6);
    val = busOut;
    oe  = busOe;
    rdN = 1'b1;
    cyc(6);
  endtask

  task automatic waitInt(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (!intN) break;
      @(negedge clk);
    end
  endtask

  // Reads both bytes and compares against the expectation for byte b.
  task automatic checkResult(input string tag, input logic [7:0] b, input int base);
    logic [7:0] lo, hi;
    logic       oe;
    int         r, fill;
    r    = expRes(b, base);
    fill = (!b[3] && r[9]) ? 6'h3f : 6'h00;
    readByte(1'b0, lo, oe);
    chk({tag, " busOe on read (R8)"}, int'(oe), 1);
    chk({tag, " low byte (R8)"}, int'(lo), r & 8'hff);
    chk({tag, " intN cleared by read (R9)"}, int'(intN), 1);
    readByte(1'b1, hi, oe);
    chk({tag, " high byte (R7 R8)"}, int'(hi), (fill << 2) | ((r >> 8) & 3));
  endtask

  initial begin
    logic [7:0] b, v;
    logic       oe;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    // Reset state
    chk("reset intN (R3)", int'(intN), 1);
    chk("reset trackOn (R3)", int'(trackOn), 0);
    chk("reset pwrState (R3)", int'(pwrState), 0);
    chk("reset busOe (R11)", int'(busOe), 0);
    csN = 1'b0;
    cyc(4);
    readByte(1'b0, v, oe);
    chk("reset result low (R8)", int'(v), 0);

    // External clock is the reset default; standby code keeps it (R3, R4).
    anaBase = 300;
    writeByte(8'h58);
    cyc(200);
    chk("no internal ticks after reset (R3)", int'(intN), 1);
    chk("tracking before ticks (R4)", int'(trackOn), 1);
    extPulses(3);
    chk("still tracking after 3 ticks (R4)", int'(trackOn), 1);
    extPulses(1);
    chk("hold on 4th tick (R4)", int'(trackOn), 0);
    chk("active while converting (R3)", int'(pwrState), 0);
    extPulses(12);
    chk("not ready after 16 ticks (R4)", int'(intN), 1);
    extPulses(1);
    chk("ready on 17th tick (R4 R9)", int'(intN), 0);
    chk("standby after conversion (R3)", int'(pwrState), 1);
    checkResult("standby conv", 8'h58, 300);

    // Chip select high masks strobes and clock (R11).
    anaBase = 123;
    writeByte(8'h58);
    csN = 1'b1;
    cyc(6);
    writeByte(8'h5d);
    @(negedge clk);
    rdN = 1'b0;
    cyc(6);
    chk("bus hi-Z with cs high (R11)", int'(busOe), 0);
    rdN = 1'b1;
    extPulses(30);
    csN = 1'b0;
    cyc(6);
    chk("masked write ignored (R11)", int'(muxPos), 0);
    chk("masked ticks ignored (R11)", int'(trackOn), 1);
    extPulses(16);
    chk("masked ticks not counted (R11)", int'(intN), 1);
    extPulses(1);
    chk("ready after full count (R11)", int'(intN), 0);
    checkResult("cs mask", 8'h58, 123);

    // Host-timed acquisition (R5).
    anaBase = 77;
    writeByte(8'hfa);
    extPulses(25);
    chk("open-ended tracking (R5)", int'(trackOn), 1);
    chk("no result while tracking (R5)", int'(intN), 1);
    writeByte(8'hda);
    chk("second write ends tracking (R5)", int'(trackOn), 0);
    extPulses(12);
    chk("not ready after 12 ticks (R5)", int'(intN), 1);
    extPulses(1);
    chk("ready on 13th tick (R5)", int'(intN), 0);
    checkResult("ext acq", 8'hda, 77);

    // Abort mid-conversion (R10).
    anaBase = 900;
    writeByte(8'hd9);
    extPulses(10);
    writeByte(8'hdb);
    chk("abort restarts tracking (R10)", int'(trackOn), 1);
    extPulses(16);
    chk("aborted count discarded (R10)", int'(intN), 1);
    extPulses(1);
    chk("restarted conversion done (R10)", int'(intN), 0);
    checkResult("abort", 8'hdb, 900);

    // Internal clock sweep over routing, polarity and address (R1 R2 R6 R7).
    for (int s = 0; s < 2; s++) begin
      for (int u = 0; u < 2; u++) begin
        for (int a = 0; a < 8; a++) begin
          b = {2'b10, 1'b0, 1'(s), 1'(u), 3'(a)};
          anaBase = a * 53 + s * 7 + u * 300;
          writeByte(b);
          chk("mux positive (R1 R2)", int'(muxPos), a);
          chk("neg is common (R1 R2)", int'(negIsCom), s);
          if (s == 0) chk("mux negative pair (R2)", int'(muxNeg), a ^ 1);
          waitInt(400);
          chk("internal clock conversion (R3 R6)", int'(intN), 0);
          checkResult("sweep", b, anaBase);
        end
      end
    end

    // Code boundaries in both polarities (R6 R7).
    for (int u = 0; u < 2; u++) begin
      for (int k = 0; k < 7; k++) begin
        int edges [7] = '{0, 1, 511, 512, 1023, 682, 341};
        b = {2'b10, 1'b0, 1'b1, 1'(u), 3'd0};
        anaBase = edges[k];
        writeByte(b);
        waitInt(400);
        chk("edge conversion done (R6)", int'(intN), 0);
        checkResult("edge code (R6 R7)", b, anaBase);
      end
    end

    // Write clears a pending interrupt (R9).
    anaBase = 640;
    writeByte(8'h98);
    waitInt(400);
    chk("pending before write (R9)", int'(intN), 0);
    writeByte(8'h98);
    chk("write clears interrupt (R9)", int'(intN), 1);
    waitInt(400);
    checkResult("rewrite", 8'h98, 640);

    // Shutdown code keeps the internal clock (R3).
    anaBase = 250;
    writeByte(8'h18);
    chk("active during shutdown-code conversion (R3)", int'(pwrState), 0);
    waitInt(400);
    chk("internal clock kept by shutdown code (R3)", int'(intN), 0);
    chk("shutdown after conversion (R3)", int'(pwrState), 2);
    checkResult("shutdown conv", 8'h18, 250);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule